// File: doc/BRIEF.md
# Embedded-Clock Frame Deserializer with Lock Detection

This block receives a serial stream that carries its own word clock. Every word travels as a 12-bit frame: one leading clock bit at 1, ten data bits, and one trailing clock bit at 0. One bit is taken on each system clock cycle where the bit-rate enable is high. The enable comes from a local reference and runs at the serial bit rate.

The block searches for the frame boundary. The boundary is the rising transition from one frame's trailing clock bit to the next frame's leading clock bit. The block then checks the clock bits of the frames that follow. It declares lock after a run of clean frames. Once locked, it presents each ten-bit word on a parallel port. A recovered word clock and a one-cycle strobe go with each word.

A lock state machine moves through initialization, data transfer and resynchronization. It drops lock after a run of frames with broken clock bits. Powerdown stops the receiver and clears lock. An output-enable flag tells the pad logic when the parallel outputs must be driven to high impedance.

Top module: `efd_rx`

## Requirements
- R1: Frame format: a frame is 12 bits long. Bit 0 is the leading clock bit (1). Bits 1 to 10 carry data, with the least significant data bit first. Bit 11 is the trailing clock bit (0). `ser_in` is sampled only on cycles with `bit_en` high. During the search, the first 0-to-1 transition between two sampled bits marks the leading clock bit.
- R2: After the boundary is found, `locked` rises after the 16th consecutive frame with both clock bits correct, and not after the 15th. This lets a clean sync pattern lock well inside 1024 word cycles. A frame with a bad clock bit during acquisition discards the candidate boundary and restarts the search.
- R3: While locked, each frame's ten data bits appear on `word_out`. Each appearance comes with a `word_vld` strobe that lasts one cycle, and there is one strobe per frame.
- R4: `word_clk` is high while frame positions 0 to 5 are received and low for positions 6 to 11. With `edge_sel`=0 a word is published when `word_clk` rises, so `word_clk` is 1 during the strobe. With `edge_sel`=1 a word is published when `word_clk` falls, so `word_clk` is 0 during the strobe.
- R5: While unlocked, `word_out` is zero, `word_vld` is low and `word_clk` is low.
- R6: While locked, one to three consecutive frames with a bad clock bit keep the lock. A correct frame clears the run.
- R7: A fourth consecutive bad frame drops lock. The state machine moves to resynchronization, and no further word is published. A fresh boundary followed by 16 clean frames restores lock.
- R8: Powerdown applies only when `pwrdn_n` and `rx_en` are both low. Powerdown clears lock, and frames received during it are ignored. When powerdown is released, the state machine restarts in initialization. Either input low on its own changes nothing.
- R9: `out_en` follows `rx_en`; 0 means the parallel outputs are to be high impedance.
- R10: After reset the block is unlocked and `word_out`, `word_vld` and `word_clk` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate enable; `ser_in` is sampled when high |
| ser_in | input | 1 | Sampled serial bit |
| edge_sel | input | 1 | 0: publish on rising `word_clk`, 1: on falling |
| pwrdn_n | input | 1 | Powerdown request, active low (needs `rx_en` low too) |
| rx_en | input | 1 | Receiver output enable |
| word_out | output | 10 | Recovered parallel word |
| word_clk | output | 1 | Recovered word clock |
| word_vld | output | 1 | One-cycle strobe for each new word |
| locked | output | 1 | Frame lock indicator |
| out_en | output | 1 | Parallel output enable (0 = high impedance) |

## Verification
Lock loss and word publication fall in the same cycle. The framer finishes the fourth bad frame and, one bit later, steps into position 0 of the next frame. That step is exactly where a word would be published with `edge_sel`=0. The bench provokes this by sending three bad frames, one good frame, three more bad frames and then a fourth consecutive bad frame with the bit enable active. It then sends a further frame. The result passes if lock has fallen, `word_out` is zero, and the strobe counter does not advance across that further frame.

// File: rtl/efd_pkg.sv
package efd_pkg;

    localparam int WORD_W  = 10;
    localparam int FRAME_W = WORD_W + 2;
    localparam int POS_W   = $clog2(FRAME_W);
    localparam int HALF    = FRAME_W / 2;

    typedef enum logic [1:0] {
        ST_PWRDN  = 2'd0,
        ST_INIT   = 2'd1,
        ST_DATA   = 2'd2,
        ST_RESYNC = 2'd3
    } lk_state_t;

    typedef struct packed {
        logic             vld;
        logic [POS_W-1:0] pos;
    } bit_step_t;

    typedef struct packed {
        logic              done;
        logic              ok;
        logic [WORD_W-1:0] data;
    } frame_rpt_t;

    function automatic logic rising_pair(input logic prev_b, input logic cur_b);
        return !prev_b && cur_b;
    endfunction

    function automatic logic [POS_W-1:0] pos_next(input logic [POS_W-1:0] p);
        return (p == POS_W'(FRAME_W - 1)) ? '0 : p + POS_W'(1);
    endfunction

endpackage

// File: rtl/efd_framer.sv
module efd_framer
    import efd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       bit_en,
    input  logic       ser_in,
    input  logic       hunt,
    output logic       sync_hit,
    output bit_step_t  step,
    output frame_rpt_t rpt
);
    localparam logic [POS_W-1:0] LAST = POS_W'(FRAME_W - 1);
    localparam logic [POS_W-1:0] DMAX = POS_W'(WORD_W);

    logic              prev_q;
    logic [POS_W-1:0]  pos_q;
    logic              start_ok_q;
    logic [WORD_W-1:0] shreg_q;

    assign sync_hit = hunt && bit_en && rising_pair(prev_q, ser_in);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            prev_q     <= 1'b0;
            pos_q      <= '0;
            start_ok_q <= 1'b0;
            shreg_q    <= '0;
            step       <= '0;
            rpt        <= '0;
        end else begin
            step.vld <= 1'b0;
            rpt.done <= 1'b0;
            if (bit_en) begin
                prev_q <= ser_in;
                if (hunt) begin
                    if (sync_hit) begin
                        pos_q      <= POS_W'(1);
                        start_ok_q <= 1'b1;
                        step.vld   <= 1'b1;
                        step.pos   <= '0;
                    end
                end else begin
                    step.vld <= 1'b1;
                    step.pos <= pos_q;
                    if (pos_q == '0) begin
                        start_ok_q <= ser_in;
                    end else if (pos_q <= DMAX) begin
                        shreg_q <= {ser_in, shreg_q[WORD_W-1:1]};
                    end else begin
                        rpt.done <= 1'b1;
                        rpt.ok   <= start_ok_q && !ser_in;
                        rpt.data <= shreg_q;
                    end
                    pos_q <= pos_next(pos_q);
                end
            end
        end
    end

    // a frame report only follows a sampled bit taken while aligned (R1)
    assert_report_aligned_R1: assert property (@(posedge clk) disable iff (rst || clr)
        rpt.done |-> $past(bit_en && !hunt));

    // the report comes out with the step of the trailing clock bit (R1)
    assert_report_last_pos_R1: assert property (@(posedge clk) disable iff (rst || clr)
        rpt.done |-> (step.vld && step.pos == LAST));

endmodule

// File: rtl/efd_lock_fsm.sv
module efd_lock_fsm
    import efd_pkg::*;
#(
    parameter int LOCK_FRAMES = 16,
    parameter int LOSS_FRAMES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd,
    input  logic       sync_hit,
    input  frame_rpt_t rpt,
    output logic       hunt,
    output logic       locked
);
    localparam int GW = $clog2(LOCK_FRAMES + 1);
    localparam int BW = $clog2(LOSS_FRAMES + 1);

    lk_state_t     state_q;
    logic          cand_q;
    logic [GW-1:0] good_q;
    logic [BW-1:0] bad_q;

    assign hunt   = (state_q == ST_INIT || state_q == ST_RESYNC) && !cand_q;
    assign locked = (state_q == ST_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_INIT;
            cand_q  <= 1'b0;
            good_q  <= '0;
            bad_q   <= '0;
        end else if (pd) begin
            state_q <= ST_PWRDN;
            cand_q  <= 1'b0;
            good_q  <= '0;
            bad_q   <= '0;
        end else begin
            case (state_q)
                ST_PWRDN: begin
                    state_q <= ST_INIT;
                end
                ST_INIT, ST_RESYNC: begin
                    if (!cand_q) begin
                        if (sync_hit) begin
                            cand_q <= 1'b1;
                            good_q <= '0;
                        end
                    end else if (rpt.done) begin
                        if (rpt.ok) begin
                            good_q <= good_q + GW'(1);
                            if (good_q == GW'(LOCK_FRAMES - 1)) begin
                                state_q <= ST_DATA;
                                bad_q   <= '0;
                            end
                        end else begin
                            cand_q <= 1'b0;
                            good_q <= '0;
                        end
                    end
                end
                ST_DATA: begin
                    if (rpt.done) begin
                        if (rpt.ok) begin
                            bad_q <= '0;
                        end else if (bad_q == BW'(LOSS_FRAMES - 1)) begin
                            state_q <= ST_RESYNC;
                            cand_q  <= 1'b0;
                            good_q  <= '0;
                            bad_q   <= '0;
                        end else begin
                            bad_q <= bad_q + BW'(1);
                        end
                    end
                end
                default: state_q <= ST_INIT;
            endcase
        end
    end

    // lock is only ever gained on a clean frame report (R2)
    assert_lock_on_good_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(rpt.done && rpt.ok));

    // outside powerdown, lock is only lost on a bad frame report (R7)
    assert_loss_on_bad_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(locked) && !$past(pd)) |-> $past(rpt.done && !rpt.ok));

endmodule

// File: rtl/efd_out_stage.sv
module efd_out_stage
    import efd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              locked,
    input  logic              edge_sel,
    input  bit_step_t         step,
    input  logic [WORD_W-1:0] data,
    output logic [WORD_W-1:0] word_out,
    output logic              word_clk,
    output logic              word_vld
);
    localparam logic [POS_W-1:0] MID = POS_W'(HALF);

    logic pub_now;

    always_comb begin
        pub_now = 1'b0;
        if (step.vld) begin
            pub_now = edge_sel ? (step.pos == MID) : (step.pos == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !locked) begin
            word_out <= '0;
            word_clk <= 1'b0;
            word_vld <= 1'b0;
        end else begin
            word_vld <= 1'b0;
            if (step.vld) begin
                word_clk <= (step.pos < MID);
            end
            if (pub_now) begin
                word_out <= data;
                word_vld <= 1'b1;
            end
        end
    end

    // an unlocked cycle leaves the parallel side quiet on the next one (R5)
    assert_quiet_unlocked_R5: assert property (@(posedge clk) disable iff (rst)
        !locked |=> (word_out == '0 && !word_vld && !word_clk));

    // a strobe sits on the word clock edge picked by edge_sel (R4)
    assert_strobe_edge_R4: assert property (@(posedge clk) disable iff (rst)
        word_vld |-> (word_clk == !$past(edge_sel)));

endmodule

// File: rtl/efd_rx.sv
module efd_rx
    import efd_pkg::*;
#(
    parameter int LOCK_FRAMES = 16,
    parameter int LOSS_FRAMES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              ser_in,
    input  logic              edge_sel,
    input  logic              pwrdn_n,
    input  logic              rx_en,
    output logic [WORD_W-1:0] word_out,
    output logic              word_clk,
    output logic              word_vld,
    output logic              locked,
    output logic              out_en
);
    logic       pd;
    logic       hunt;
    logic       sync_hit;
    bit_step_t  step;
    frame_rpt_t rpt;

    assign pd     = !pwrdn_n && !rx_en;
    assign out_en = rx_en;

    efd_framer u_framer (
        .clk      (clk),
        .rst      (rst),
        .clr      (pd),
        .bit_en   (bit_en),
        .ser_in   (ser_in),
        .hunt     (hunt),
        .sync_hit (sync_hit),
        .step     (step),
        .rpt      (rpt)
    );

    efd_lock_fsm #(
        .LOCK_FRAMES (LOCK_FRAMES),
        .LOSS_FRAMES (LOSS_FRAMES)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .pd       (pd),
        .sync_hit (sync_hit),
        .rpt      (rpt),
        .hunt     (hunt),
        .locked   (locked)
    );

    efd_out_stage u_out (
        .clk      (clk),
        .rst      (rst),
        .locked   (locked),
        .edge_sel (edge_sel),
        .step     (step),
        .data     (rpt.data),
        .word_out (word_out),
        .word_clk (word_clk),
        .word_vld (word_vld)
    );

    // powerdown clears lock on the following cycle (R8)
    assert_pd_unlock_R8: assert property (@(posedge clk) disable iff (rst)
        pd |=> !locked);

    // a detected boundary ends the search in the next cycle (R1)
    assert_align_ends_hunt_R1: assert property (@(posedge clk) disable iff (rst || pd)
        sync_hit |=> !hunt);

endmodule

// File: tb/efd_rx_tb_top.sv
module efd_rx_tb_top;
    localparam int CLK_P = 10;
    localparam int NV    = 8;
    localparam logic [9:0] VEC [NV] = '{10'h001, 10'h200, 10'h155, 10'h2AA,
                                        10'h3FF, 10'h0F0, 10'h30C, 10'h1E3};

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_en = 1'b0;
    logic       ser_in = 1'b0;
    logic       edge_sel = 1'b0;
    logic       pwrdn_n = 1'b1;
    logic       rx_en = 1'b1;
    logic [9:0] word_out;
    logic       word_clk;
    logic       word_vld;
    logic       locked;
    logic       out_en;

    int checks = 0;
    int errors = 0;
    int vld_total = 0;
    logic [9:0] cap_w [256];
    logic       cap_c [256];
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    efd_rx dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .ser_in(ser_in),
        .edge_sel(edge_sel), .pwrdn_n(pwrdn_n), .rx_en(rx_en),
        .word_out(word_out), .word_clk(word_clk), .word_vld(word_vld),
        .locked(locked), .out_en(out_en)
    );

    always @(negedge clk) begin
        if (word_vld) begin
            if (vld_total < 256) begin
                cap_w[vld_total] = word_out;
                cap_c[vld_total] = word_clk;
            end
            vld_total = vld_total + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_en = 1'b1;
        ser_in = b;
        @(negedge clk);
        bit_en = 1'b0;
    endtask

    task automatic send_frame(input logic [9:0] w, input bit bad);
        send_bit(1'b1);
        for (int k = 0; k < 10; k++) send_bit(w[k]);
        send_bit(bad ? 1'b1 : 1'b0);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(locked == 1'b0, "R10 locked", locked, 0);
        chk(word_out == '0 && !word_vld && !word_clk, "R10 outputs", word_out, 0);
        chk(out_en == 1'b1, "R9 out_en high", out_en, 1);

        // R1 R2: idle zeros, then sync frames
        for (int k = 0; k < 6; k++) send_bit(1'b0);
        for (int f = 0; f < 15; f++) send_frame(10'h000, 1'b0);
        settle();
        chk(locked == 1'b0, "R2 no lock after 15", locked, 0);
        chk(vld_total == 0 && word_out == '0, "R5 quiet while unlocked", vld_total, 0);
        send_frame(10'h000, 1'b0);
        settle();
        chk(locked == 1'b1, "R2 lock after 16", locked, 1);

        // R1 R3 R4: table walk, rising-edge publish
        base = vld_total;
        for (int i = 0; i < NV; i++) send_frame(VEC[i], 1'b0);
        send_frame(10'h000, 1'b0);
        settle();
        chk(vld_total - base == NV + 1, "R3 strobe count", vld_total - base, NV + 1);
        for (int i = 0; i < NV; i++) begin
            chk(cap_w[base+i+1] == VEC[i], "R1 R3 word data", cap_w[base+i+1], VEC[i]);
            chk(cap_c[base+i+1] == 1'b1, "R4 rising edge", cap_c[base+i+1], 1);
        end

        // R4: falling-edge publish
        edge_sel = 1'b1;
        base = vld_total;
        send_frame(10'h2C5, 1'b0);
        send_frame(10'h13A, 1'b0);
        send_frame(10'h000, 1'b0);
        settle();
        chk(vld_total - base == 3, "R4 falling count", vld_total - base, 3);
        chk(cap_w[base+1] == 10'h2C5, "R4 falling word A", cap_w[base+1], 10'h2C5);
        chk(cap_w[base+2] == 10'h13A, "R4 falling word B", cap_w[base+2], 10'h13A);
        chk(cap_c[base+1] == 1'b0 && cap_c[base+2] == 1'b0, "R4 falling edge", cap_c[base+1], 0);
        edge_sel = 1'b0;

        // R6: bad runs shorter than four keep lock
        for (int f = 0; f < 3; f++) send_frame(10'h3FF, 1'b1);
        send_frame(10'h000, 1'b0);
        for (int f = 0; f < 3; f++) send_frame(10'h3FF, 1'b1);
        settle();
        chk(locked == 1'b1, "R6 lock held", locked, 1);

        // R7 R5: fourth bad frame drops lock; no publish afterwards
        send_frame(10'h3FF, 1'b1);
        settle();
        chk(locked == 1'b0, "R7 lock lost", locked, 0);
        chk(word_out == '0, "R5 word cleared", word_out, 0);
        base = vld_total;
        send_frame(10'h000, 1'b0);
        settle();
        chk(vld_total == base, "R7 no strobe after loss", vld_total - base, 0);
        for (int f = 0; f < 16; f++) send_frame(10'h000, 1'b0);
        settle();
        chk(locked == 1'b1, "R7 relock", locked, 1);

        // R8 R9: powerdown needs both inputs low
        pwrdn_n = 1'b0;
        send_frame(10'h000, 1'b0);
        settle();
        chk(locked == 1'b1, "R8 pwrdn_n alone", locked, 1);
        pwrdn_n = 1'b1;
        rx_en = 1'b0;
        @(negedge clk);
        chk(out_en == 1'b0, "R9 out_en low", out_en, 0);
        send_frame(10'h000, 1'b0);
        settle();
        chk(locked == 1'b1, "R8 rx_en alone", locked, 1);
        pwrdn_n = 1'b0;
        settle();
        chk(locked == 1'b0, "R8 powerdown unlock", locked, 0);
        base = vld_total;
        for (int f = 0; f < 20; f++) send_frame(10'h000, 1'b0);
        settle();
        chk(locked == 1'b0 && vld_total == base, "R8 frames ignored", locked, 0);
        pwrdn_n = 1'b1;
        rx_en = 1'b1;
        settle();
        for (int f = 0; f < 15; f++) send_frame(10'h000, 1'b0);
        settle();
        chk(locked == 1'b0, "R8 restart no early lock", locked, 0);
        send_frame(10'h000, 1'b0);
        settle();
        chk(locked == 1'b1, "R8 restart relock", locked, 1);

        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule